// File: doc/BRIEF.md
# SPI Serial Clock and Frame Engine

This block is the bit-level half of an SPI master. It accepts one word at a time over a valid/ready handshake, shifts it out on the serial data output and, during the same clock toggles, samples the serial data input to build a received word, which it presents with a one-cycle valid strobe. The serial clock is derived from the system clock by an even divide ratio, and the line-level behaviour is put together from four separate control bits: idle level, capture edge, first-edge delay and frame-start edge. The four classic SPI modes are reached by setting those bits in combination rather than through a built-in mode number.

Word length and bit order are programmable. A separate frame/select output follows a software-set level, so asserting or deasserting the device select is a matter of flipping that level. All configuration is expected to come from a register bank outside this block and to stay still while a word is in flight.

Top module: `spi_frame_engine`

## Requirements
- R1: In the cycle after reset, the serial clock sits at the idle level, busy is 0, rx_valid is 0, mosi is 0, rx_data is 0 and frame_o is 1.
- R2: While a word is in flight the serial clock toggles once every H system clocks, where H is 1 for a divide ratio of 0 and otherwise (ratio+1)/2 rounded down, so ratios 0 and 2 both give H = 1 and an odd ratio behaves as the next even one.
- R3: With no word in flight the serial clock is held at the level of sclk_idle_hi (0 = low, 1 = high), following it one cycle later.
- R4: miso is sampled on the toggle whose new clock level is 1 when cap_on_fall = 0, and 0 when cap_on_fall = 1.
- R5: The first toggle of a word accepted from idle occurs H cycles after the accepting edge, plus 2H more when first_edge_dly = 1 and start_on_fall = 0, or H more when first_edge_dly = 1 and start_on_fall = 1.
- R6: A word has L bits and takes 2L toggles, where L is word_len, with 0 treated as 1 and values above DATA_W treated as DATA_W; the clock ends each word back at its idle level.
- R7: bit_order = 1 sends bit 0 first and stores the first received bit in rx_data bit 0; any other value sends bit L-1 first and stores the first received bit in bit L-1; rx_data bits at L and above are 0.
- R8: mosi presents the first bit at the edge that accepts a word and moves to the next bit at each capture toggle, and changes at no other time.
- R9: tx_ready is high when idle and during the cycle before a word's final toggle; a word accepted at that final toggle starts its first toggle H cycles later, with no lead delay.
- R10: busy rises at the edge that accepts a word and falls at the edge that raises rx_valid for the last word.
- R11: rx_valid is a one-cycle pulse at a word's final toggle, and rx_data holds that word until the next word completes.
- R12: frame_o follows frame_level one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_ratio | input | 8 | Serial clock divide ratio (even) |
| cap_on_fall | input | 1 | Capture edge select: 0 rising, 1 falling |
| sclk_idle_hi | input | 1 | Serial clock idle level |
| first_edge_dly | input | 1 | Add a lead delay before the first toggle |
| start_on_fall | input | 1 | Frame-start edge; picks a half-period (1) or full-period (0) lead delay |
| frame_level | input | 1 | Level to drive on the frame/select line |
| word_len | input | 6 | Bits per word |
| bit_order | input | 2 | 1 = LSB first, else MSB first |
| tx_valid | input | 1 | A transmit word is offered |
| tx_ready | output | 1 | The offered word is taken at this edge |
| tx_data | input | 32 | Transmit word |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | 32 | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| frame_o | output | 1 | Frame/select line |
| busy | output | 1 | A word is in flight |

## Verification
The crowded cycle is a word's final toggle: when that toggle is also a capture edge, the last miso bit, the rx_valid strobe, the busy decision and the acceptance of the next word with its first mosi bit all land on one edge. The bench provokes this by queuing several words back to back, in modes where the last toggle is and is not a capture, and by pushing a word mid-flight. A behavioural model that schedules toggles by absolute cycle number predicts every output each cycle, so a lost final bit, a spurious lead delay or a dropped acceptance shows as a mismatch on rx_data, sclk or tx_ready.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  // Position of bit k within an L-bit word for the chosen order
  function automatic int unsigned order_pos(input int unsigned k, input int unsigned len,
                                            input logic lsb_first);
    return lsb_first ? k : (len - 1 - k);
  endfunction
  localparam logic [1:0] ORDER_LSB = 2'd1;
endpackage

// File: rtl/spi_eng_timer.sv
module spi_eng_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             lead_en,
  input  logic             lead_short,
  input  logic             run,
  input  logic             load,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 2;

  logic [DIV_W:0]   inc;
  logic [DIV_W-1:0] half;
  logic [CNT_W-1:0] half_w, lead_amt, cnt;

  always_comb begin
    inc    = {1'b0, div_ratio} + 1'b1;
    half   = (div_ratio == '0) ? DIV_W'(1) : inc[DIV_W:1];
    half_w = CNT_W'(half);
    if (!lead_en)        lead_amt = '0;
    else if (lead_short) lead_amt = half_w;
    else                 lead_amt = half_w << 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (run ? '0 : lead_amt) + half_w - 1'b1;
    end else if (run) begin
      cnt <= (cnt == '0) ? half_w - 1'b1 : cnt - 1'b1;
    end
  end

  assign tick = run && (cnt == '0);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < 3 * half_w)); // R5
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W + 1),
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              lsb_first,
  input  logic [IDX_W-1:0]  len,
  input  logic              cap,
  input  logic              done,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  logic [DATA_W-1:0] word_q, rx_sh, rx_nx, rx_lsb;
  logic [IDX_W-1:0]  k, k_nx;
  logic [POS_W-1:0]  top_pos;

  function automatic logic [POS_W-1:0] pos_of(input logic [IDX_W-1:0] kk);
    return POS_W'(order_pos(32'(kk), 32'(len), lsb_first));
  endfunction

  always_comb begin
    top_pos = POS_W'(len - 1'b1);
    rx_lsb  = rx_sh >> 1;
    rx_lsb[top_pos] = miso;
    if (!cap)          rx_nx = rx_sh;
    else if (lsb_first) rx_nx = rx_lsb;
    else               rx_nx = {rx_sh[DATA_W-2:0], miso};
    k_nx = k + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q   <= '0;
      rx_sh    <= '0;
      k        <= '0;
      mosi     <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= done;
      if (done) rx_data <= rx_nx;
      if (load) begin
        word_q <= tx_word;
        rx_sh  <= '0;
        k      <= '0;
        mosi   <= tx_word[pos_of('0)];
      end else if (cap) begin
        rx_sh <= rx_nx;
        k     <= k_nx;
        if (k_nx < len) mosi <= word_q[pos_of(k_nx)];
      end
    end
  end

  AST_MOSI_MOVES: assert property (@(posedge clk) disable iff (rst)
    (mosi != $past(mosi)) |-> $past(load || cap)); // R8
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_ratio,
  input  logic              cap_on_fall,
  input  logic              sclk_idle_hi,
  input  logic              first_edge_dly,
  input  logic              start_on_fall,
  input  logic              frame_level,
  input  logic [LEN_W-1:0]  word_len,
  input  logic [1:0]        bit_order,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              frame_o,
  output logic              busy
);
  import spi_eng_pkg::*;

  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam int TG_W  = IDX_W + 1;

  logic [IDX_W-1:0] len_eff;
  logic [TG_W-1:0]  tg, tg_last;
  logic             tick, last, accept, cap;

  always_comb begin
    if (word_len == '0)                   len_eff = IDX_W'(1);
    else if (32'(word_len) > DATA_W)      len_eff = IDX_W'(DATA_W);
    else                                  len_eff = IDX_W'(word_len);
    tg_last  = {len_eff, 1'b0} - 1'b1;
    last     = tick && (tg == tg_last);
    tx_ready = !busy || last;
    accept   = tx_valid && tx_ready;
    cap      = tick && ((~sclk) ^ cap_on_fall);
  end

  spi_eng_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .div_ratio(div_ratio),
    .lead_en(first_edge_dly), .lead_short(start_on_fall),
    .run(busy), .load(accept), .tick(tick)
  );

  spi_eng_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(accept), .tx_word(tx_data),
    .lsb_first(bit_order == ORDER_LSB), .len(len_eff), .cap(cap),
    .done(last), .miso(miso), .mosi(mosi), .rx_data(rx_data),
    .rx_valid(rx_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sclk    <= sclk_idle_hi;
      tg      <= '0;
      frame_o <= 1'b1;
    end else begin
      frame_o <= frame_level;
      if (!busy) begin
        sclk <= sclk_idle_hi;
      end else if (tick) begin
        sclk <= ~sclk;
        tg   <= tg + 1'b1;
        if (last) busy <= 1'b0;
      end
      if (accept) begin
        busy <= 1'b1;
        tg   <= '0;
      end
    end
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(sclk_idle_hi)) |-> (sclk == sclk_idle_hi)); // R3
  AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && (sclk != $past(sclk))) |-> $past(tick)); // R2
  AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R11
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rx_valid); // R10
endmodule

// File: tb/spi_frame_engine_test.sv
module spi_frame_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  div_ratio = 8'd2;
  logic        cap_on_fall = 1'b0, sclk_idle_hi = 1'b0, first_edge_dly = 1'b0, start_on_fall = 1'b0;
  logic        frame_level = 1'b1;
  logic [5:0]  word_len = 6'd8;
  logic [1:0]  bit_order = 2'd0;
  logic        tx_ready, rx_valid, sclk, mosi, frame_o, busy;
  logic [31:0] rx_data;
  logic        miso = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [31:0] wq [0:63];
  int          wr = 0, rd = 0;
  wire         tx_valid = (rd != wr);
  wire [31:0]  tx_data  = wq[rd % 64];

  int checks = 0, fails = 0, cyc = 0, ncyc = 0;

  always #10 clk = ~clk;

  spi_frame_engine uut (
    .clk(clk), .rst(rst), .div_ratio(div_ratio), .cap_on_fall(cap_on_fall),
    .sclk_idle_hi(sclk_idle_hi), .first_edge_dly(first_edge_dly),
    .start_on_fall(start_on_fall), .frame_level(frame_level), .word_len(word_len),
    .bit_order(bit_order), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso),
    .frame_o(frame_o), .busy(busy)
  );

  // ---------------- behavioural reference ----------------
  bit          m_busy, m_sclk, m_mosi, m_rxv, m_sel;
  int          m_tg, m_k, m_next;
  logic [31:0] m_word, m_rx, m_rxd;

  function automatic int eff_len();
    if (word_len == 0) return 1;
    if (word_len > 32) return 32;
    return int'(word_len);
  endfunction
  function automatic int half_of();
    return (div_ratio == 0) ? 1 : (int'(div_ratio) + 1) / 2;
  endfunction
  function automatic int bpos(int k);
    return (bit_order == 2'd1) ? k : eff_len() - 1 - k;
  endfunction

  always @(posedge clk) begin
    bit was_idle, can_take;
    int L, hf;
    cyc   = cyc + 1;
    m_rxv = 1'b0;
    if (rst) begin
      m_busy = 0; m_sclk = sclk_idle_hi; m_mosi = 0; m_rxd = '0; m_sel = 1; m_tg = 0;
    end else begin
      L = eff_len(); hf = half_of();
      m_sel = frame_level;
      was_idle = !m_busy;
      can_take = was_idle;
      if (was_idle) m_sclk = sclk_idle_hi;
      else if (cyc == m_next) begin
        m_tg   = m_tg + 1;
        m_sclk = !m_sclk;
        if (m_sclk != cap_on_fall) begin
          m_rx[bpos(m_k)] = miso;
          m_k = m_k + 1;
          if (m_k < L) m_mosi = m_word[bpos(m_k)];
        end
        if (m_tg == 2 * L) begin
          m_rxv = 1; m_rxd = m_rx; m_busy = 0; can_take = 1;
        end else m_next = cyc + hf;
      end
      if (can_take && (rd != wr)) begin
        m_word = wq[rd % 64];
        rd <= rd + 1;
        m_busy = 1; m_tg = 0; m_k = 0; m_rx = '0;
        m_mosi = m_word[bpos(0)];
        m_next = cyc + hf;
        if (was_idle && first_edge_dly) m_next = m_next + (start_on_fall ? hf : 2 * hf);
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual=%h expected=%h", req, what, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    bit exp_ready;
    ncyc++;
    if (ncyc > 150000) begin
      checks++; fails++;
      $display("FAIL R10 watchdog: actual=busy_stuck expected=completion");
      finish_run();
    end
    if (!rst) begin
      exp_ready = !m_busy || ((m_next == cyc + 1) && (m_tg == 2 * eff_len() - 1));
      chk("R2 R3 R5 R6", "sclk", 32'(sclk), 32'(m_sclk));
      chk("R8", "mosi", 32'(mosi), 32'(m_mosi));
      chk("R10", "busy", 32'(busy), 32'(m_busy));
      chk("R11", "rx_valid", 32'(rx_valid), 32'(m_rxv));
      chk("R4 R6 R7", "rx_data", rx_data, m_rxd);
      chk("R9", "tx_ready", 32'(tx_ready), 32'(exp_ready));
      chk("R12", "frame_o", 32'(frame_o), 32'(m_sel));
    end
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso <= lfsr[0];
  end

  task automatic push(input logic [31:0] w);
    wq[wr % 64] = w;
    wr = wr + 1;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while ((rd != wr) || m_busy);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_mode(input int m);
    case (m)
      0: {cap_on_fall, sclk_idle_hi, first_edge_dly, start_on_fall} = 4'b1010;
      1: {cap_on_fall, sclk_idle_hi, first_edge_dly, start_on_fall} = 4'b0001;
      2: {cap_on_fall, sclk_idle_hi, first_edge_dly, start_on_fall} = 4'b0111;
      default: {cap_on_fall, sclk_idle_hi, first_edge_dly, start_on_fall} = 4'b1100;
    endcase
  endtask

  int seq = 0;
  function automatic logic [31:0] next_word();
    seq++;
    return 32'hA5C3_0F1E ^ (32'(seq) * 32'h9E37_79B9);
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state observed at the ports
    chk("R1", "reset sclk", 32'(sclk), 32'd0);
    chk("R1", "reset busy", 32'(busy), 32'd0);
    chk("R1", "reset rx_valid", 32'(rx_valid), 32'd0);
    chk("R1", "reset mosi", 32'(mosi), 32'd0);
    chk("R1", "reset rx_data", rx_data, 32'd0);

    // four modes, two divide ratios, both orders, back-to-back words
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        @(negedge clk);
        set_mode(m);
        div_ratio = (d == 0) ? 8'd2 : 8'd3;
        bit_order = (m[0] ^ d[0]) ? 2'd1 : 2'd0;
        word_len  = 6'd8;
        frame_level = m[0];
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) push(next_word());
        wait_idle();
      end
    end

    // R2: ratio 0 as fastest rate, 1-bit words (R6) back to back
    @(negedge clk); set_mode(3); div_ratio = 8'd0; word_len = 6'd1;
    for (int i = 0; i < 3; i++) push(next_word());
    wait_idle();

    // R6: length 0 treated as one bit; lead delay short (R5)
    @(negedge clk); set_mode(2); div_ratio = 8'd6; word_len = 6'd0;
    push(next_word()); wait_idle();

    // R6: length above the data width clamps; R7 LSB first
    @(negedge clk); set_mode(0); div_ratio = 8'd4; word_len = 6'd40; bit_order = 2'd1;
    push(next_word()); push(next_word()); wait_idle();

    // R7: full width MSB first, odd ratio (R2), with format value 2 meaning MSB
    @(negedge clk); set_mode(1); div_ratio = 8'd9; word_len = 6'd32; bit_order = 2'd2;
    push(next_word()); wait_idle();

    // R9: word arriving mid-flight is taken at the final toggle
    @(negedge clk); set_mode(0); div_ratio = 8'd2; word_len = 6'd5; bit_order = 2'd0;
    frame_level = 1'b0;
    push(next_word());
    repeat (4) @(negedge clk);
    push(next_word());
    wait_idle();
    frame_level = 1'b1;

    // R3: idle level follows the control bit with nothing queued
    @(negedge clk); sclk_idle_hi = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3", "idle high sclk", 32'(sclk), 32'd1);
    sclk_idle_hi = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3", "idle low sclk", 32'(sclk), 32'd0);

    finish_run();
  end
endmodule